// File: doc/BRIEF.md
# Card contact power sequencer

This block switches a card's contacts on and off in a fixed order and at fixed times. It runs on a slow tick, one period T, taken from a free-running clock divided by `TICK_DIV`. Internally it counts half-ticks, so that an event can fall on a half period. A host asks for a session by pulling an active-low request line low. The block accepts the request only when a card is present and the supply alarm is quiet. It then enables, in turn, the voltage booster, the supply (and releases the low-impedance clamp), the data buffer, a window where the host's reset-control line gates the card clock, and finally the card reset buffer.

When the host releases the request, the block takes the contacts down again in reverse order, one tick per step. An overcurrent, a short, a supply drop or a card removal during a session forces the same shutdown automatically and pulls the active-low OFF flag to the host. OFF clears when the shutdown completes. If the cause was removal, OFF stays asserted until a card is back in the slot.

Top module: `cardpwr_seq`

## Requirements
- R1: During and after reset, with no request, the booster, supply, data buffer, clock and reset outputs are 0, the clamp output is 1 and OFF (`off_n`) is 1.
- R2: A session starts only on a high-to-low change of `start_n` seen while idle, with `card_present`=1 and `supply_alarm`=0. A request held low from reset, or a falling edge without a card or with the alarm set, leaves every output at its idle value.
- R3: `boost_en` rises on the first clock edge after the accepted request.
- R4: `vcc_en` rises and `clamp_en` falls together, 1.5 T (3 half-ticks) after the accept edge.
- R5: `io_en` rises 4 T after the accept edge.
- R6: From 4 T to 7 T, `card_clk_en` equals `host_rst_ctl` and `card_rst` is 0.
- R7: From 7 T on, `card_clk_en` is 1 and `card_rst` is the inverse of `host_rst_ctl`.
- R8: When `start_n` goes high during a session, `card_rst` falls on the next edge. Clock, data buffer and supply then turn off 1 T, 2 T and 3 T later. After 4 T the booster stops and the clamp returns. Contacts that were never enabled stay off, and the clamp stays on if the supply had not been enabled.
- R9: Request activity during shutdown is ignored. After shutdown a new falling edge of `start_n` is needed.
- R10: An overcurrent, short, supply alarm or card absence during a session drives `off_n` to 0 on the next edge and starts the R8 shutdown.
- R11: After a shutdown caused by overcurrent, short or supply alarm, `off_n` returns to 1 on the edge that ends the shutdown.
- R12: After a shutdown caused by card removal, `off_n` stays 0 until `card_present` is 1 again while idle. It then returns to 1 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running internal clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_n | input | 1 | Host session request, active low |
| card_present | input | 1 | Card detected in the slot |
| supply_alarm | input | 1 | Supply supervisor reports low supply |
| fault_ovc | input | 1 | Supply overcurrent detected |
| fault_short | input | 1 | Short between supply and a contact |
| host_rst_ctl | input | 1 | Host reset-control line |
| boost_en | output | 1 | Voltage booster enable |
| clamp_en | output | 1 | Low-impedance contact clamp enable |
| vcc_en | output | 1 | Card supply enable |
| io_en | output | 1 | Card data buffer enable |
| card_clk_en | output | 1 | Card clock gate |
| card_rst | output | 1 | Card reset contact level |
| off_n | output | 1 | Fault / shutdown flag to host, active low |

## Verification
Full activations are compared with the arithmetic schedule on every cycle while the host reset-control line toggles. This separates the window where that line gates the clock from the later phase where it drives only the reset contact. Shutdowns are started at several points: before the supply step, inside the clock window and in the fully active state. This shows whether each contact goes down only if it was up, and whether the held clock level is kept for one tick. Normal release, overcurrent, short and removal are each used as the cause, so that the OFF flag's clearing and its latch after removal are told apart. Requests held through reset, requests without a card or with the alarm set, and toggles during shutdown confirm that only a clean falling edge in idle starts a session.

// File: rtl/cardpwr_pkg.sv
`timescale 1ns/1ps
package cardpwr_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RAMP = 2'd1,
      ST_LIVE = 2'd2,
      ST_DOWN = 2'd3
   } seq_state_e;

   typedef struct packed {
      logic boost;
      logic clamp;
      logic vcc;
      logic io;
      logic clk;
      logic rst;
   } contacts_t;
endpackage

// File: rtl/cardpwr_tick.sv
`timescale 1ns/1ps
module cardpwr_tick #(
   parameter int HALF_DIV = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic half_stb
);
   localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

   generate
      if (HALF_DIV == 1) begin : g_direct
         assign half_stb = ~restart;
      end else begin : g_count
         logic [CNT_W-1:0] cnt;
         assign half_stb = (cnt == CNT_W'(HALF_DIV - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt <= '0;
            else if (restart || half_stb)
               cnt <= '0;
            else
               cnt <= cnt + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/cardpwr_fsm.sv
`timescale 1ns/1ps
module cardpwr_fsm
   import cardpwr_pkg::*;
#(
   parameter int T2_HALF   = 3,
   parameter int T3_HALF   = 8,
   parameter int T5_HALF   = 14,
   parameter int STEP_HALF = 2,
   parameter int HT_W      = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            half_stb,
   input  logic            start_n,
   input  logic            card_present,
   input  logic            supply_alarm,
   input  logic            fault_ovc,
   input  logic            fault_short,
   input  logic            host_rst_ctl,
   output logic            restart,
   output seq_state_e      state,
   output logic [HT_W-1:0] ht,
   output logic            vcc_on,
   output logic            io_on,
   output logic            clk_hold,
   output logic            off_n
);
   localparam int DONE_HALF = 4 * STEP_HALF;

   logic prev_start_n;
   logic emerg, gone;
   logic accept, fault_any, in_session, go_down, down_end;

   always_comb begin
      fault_any  = fault_ovc | fault_short | supply_alarm | ~card_present;
      in_session = (state == ST_RAMP) || (state == ST_LIVE);
      accept     = (state == ST_IDLE) && prev_start_n && !start_n
                   && card_present && !supply_alarm;
      go_down    = in_session && (fault_any || start_n);
      restart    = accept || go_down;
      down_end   = (state == ST_DOWN) && half_stb && (ht == HT_W'(DONE_HALF - 1));
   end

   assign off_n = ~(emerg | gone);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state        <= ST_IDLE;
         ht           <= '0;
         prev_start_n <= 1'b0;
         vcc_on       <= 1'b0;
         io_on        <= 1'b0;
         clk_hold     <= 1'b0;
         emerg        <= 1'b0;
         gone         <= 1'b0;
      end else begin
         prev_start_n <= start_n;

         if (go_down) begin
            state    <= ST_DOWN;
            ht       <= '0;
            vcc_on   <= (state == ST_LIVE) || (ht >= HT_W'(T2_HALF));
            io_on    <= (state == ST_LIVE) || (ht >= HT_W'(T3_HALF));
            clk_hold <= (state == ST_LIVE) || ((ht >= HT_W'(T3_HALF)) && host_rst_ctl);
         end else begin
            case (state)
               ST_IDLE: begin
                  if (accept) begin
                     state <= ST_RAMP;
                     ht    <= '0;
                  end
               end
               ST_RAMP: begin
                  if (half_stb) begin
                     ht <= ht + 1'b1;
                     if (ht == HT_W'(T5_HALF - 1))
                        state <= ST_LIVE;
                  end
               end
               ST_LIVE: begin
                  ht <= ht;
               end
               ST_DOWN: begin
                  if (down_end) begin
                     state <= ST_IDLE;
                     ht    <= '0;
                  end else if (half_stb) begin
                     ht <= ht + 1'b1;
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end

         if (down_end)
            emerg <= 1'b0;
         else if ((in_session || (state == ST_DOWN)) && fault_any)
            emerg <= 1'b1;

         if ((state == ST_IDLE) && card_present)
            gone <= 1'b0;
         else if ((state != ST_IDLE) && !card_present)
            gone <= 1'b1;
      end
   end
endmodule

// File: rtl/cardpwr_drive.sv
`timescale 1ns/1ps
module cardpwr_drive
   import cardpwr_pkg::*;
#(
   parameter int T2_HALF   = 3,
   parameter int T3_HALF   = 8,
   parameter int STEP_HALF = 2,
   parameter int HT_W      = 4
) (
   input  seq_state_e      state,
   input  logic [HT_W-1:0] ht,
   input  logic            vcc_on,
   input  logic            io_on,
   input  logic            clk_hold,
   input  logic            host_rst_ctl,
   output contacts_t       pins
);
   localparam int CLK_OFF = STEP_HALF;
   localparam int IO_OFF  = 2 * STEP_HALF;
   localparam int VCC_OFF = 3 * STEP_HALF;

   logic ramp_vcc, ramp_io;

   always_comb begin
      ramp_vcc = (ht >= HT_W'(T2_HALF));
      ramp_io  = (ht >= HT_W'(T3_HALF));
      pins     = '{boost: 1'b0, clamp: 1'b1, vcc: 1'b0, io: 1'b0, clk: 1'b0, rst: 1'b0};
      case (state)
         ST_RAMP: begin
            pins.boost = 1'b1;
            pins.vcc   = ramp_vcc;
            pins.clamp = ~ramp_vcc;
            pins.io    = ramp_io;
            pins.clk   = ramp_io & host_rst_ctl;
         end
         ST_LIVE: begin
            pins.boost = 1'b1;
            pins.vcc   = 1'b1;
            pins.clamp = 1'b0;
            pins.io    = 1'b1;
            pins.clk   = 1'b1;
            pins.rst   = ~host_rst_ctl;
         end
         ST_DOWN: begin
            pins.boost = 1'b1;
            pins.clamp = ~vcc_on;
            pins.clk   = clk_hold & (ht < HT_W'(CLK_OFF));
            pins.io    = io_on & (ht < HT_W'(IO_OFF));
            pins.vcc   = vcc_on & (ht < HT_W'(VCC_OFF));
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/cardpwr_seq.sv
`timescale 1ns/1ps
module cardpwr_seq
   import cardpwr_pkg::*;
#(
   parameter int TICK_DIV  = 64,
   parameter int T2_HALF   = 3,
   parameter int T3_HALF   = 8,
   parameter int T5_HALF   = 14,
   parameter int STEP_HALF = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_n,
   input  logic card_present,
   input  logic supply_alarm,
   input  logic fault_ovc,
   input  logic fault_short,
   input  logic host_rst_ctl,
   output logic boost_en,
   output logic clamp_en,
   output logic vcc_en,
   output logic io_en,
   output logic card_clk_en,
   output logic card_rst,
   output logic off_n
);
   localparam int HALF_DIV  = TICK_DIV / 2;
   localparam int DONE_HALF = 4 * STEP_HALF;
   localparam int MAX_HALF  = (T5_HALF > DONE_HALF) ? T5_HALF : DONE_HALF;
   localparam int HT_W      = $clog2(MAX_HALF + 1);

   generate
      if ((TICK_DIV < 2) || (TICK_DIV % 2 != 0)) begin : g_bad_div
         $error("TICK_DIV must be even and at least 2");
      end
      if (!((T2_HALF > 0) && (T2_HALF < T3_HALF) && (T3_HALF < T5_HALF))) begin : g_bad_order
         $error("activation points must satisfy 0 < T2 < T3 < T5");
      end
      if (STEP_HALF < 1) begin : g_bad_step
         $error("STEP_HALF must be at least 1");
      end
   endgenerate

   logic            restart, half_stb;
   seq_state_e      state;
   logic [HT_W-1:0] ht;
   logic            vcc_on, io_on, clk_hold;
   contacts_t       pins;

   cardpwr_tick #(.HALF_DIV(HALF_DIV)) u_tick (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (restart),
      .half_stb (half_stb)
   );

   cardpwr_fsm #(
      .T2_HALF(T2_HALF), .T3_HALF(T3_HALF), .T5_HALF(T5_HALF),
      .STEP_HALF(STEP_HALF), .HT_W(HT_W)
   ) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .half_stb     (half_stb),
      .start_n      (start_n),
      .card_present (card_present),
      .supply_alarm (supply_alarm),
      .fault_ovc    (fault_ovc),
      .fault_short  (fault_short),
      .host_rst_ctl (host_rst_ctl),
      .restart      (restart),
      .state        (state),
      .ht           (ht),
      .vcc_on       (vcc_on),
      .io_on        (io_on),
      .clk_hold     (clk_hold),
      .off_n        (off_n)
   );

   cardpwr_drive #(
      .T2_HALF(T2_HALF), .T3_HALF(T3_HALF), .STEP_HALF(STEP_HALF), .HT_W(HT_W)
   ) u_drive (
      .state        (state),
      .ht           (ht),
      .vcc_on       (vcc_on),
      .io_on        (io_on),
      .clk_hold     (clk_hold),
      .host_rst_ctl (host_rst_ctl),
      .pins         (pins)
   );

   assign boost_en    = pins.boost;
   assign clamp_en    = pins.clamp;
   assign vcc_en      = pins.vcc;
   assign io_en       = pins.io;
   assign card_clk_en = pins.clk;
   assign card_rst    = pins.rst;
endmodule

// File: rtl/cardpwr_seq_chk.sv
`timescale 1ns/1ps
module cardpwr_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic start_n,
   input logic card_present,
   input logic supply_alarm,
   input logic fault_ovc,
   input logic fault_short,
   input logic host_rst_ctl,
   input logic boost_en,
   input logic clamp_en,
   input logic vcc_en,
   input logic io_en,
   input logic card_clk_en,
   input logic card_rst,
   input logic off_n
);
   p_accept_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(boost_en) |-> $past(!start_n && card_present && !supply_alarm));

   p_supply_clamp_r4: assert property (@(posedge clk) disable iff (!rst_n)
      vcc_en |-> (boost_en && !clamp_en));

   p_io_after_vcc_r5: assert property (@(posedge clk) disable iff (!rst_n)
      io_en |-> vcc_en);

   p_clk_after_io_r6: assert property (@(posedge clk) disable iff (!rst_n)
      card_clk_en |-> io_en);

   p_rst_inverse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      card_rst |-> (card_clk_en && !host_rst_ctl));

   p_clamp_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !boost_en |-> clamp_en);

   p_fault_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (vcc_en && (fault_ovc || fault_short || supply_alarm)) |=> !off_n);

   p_removal_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!off_n && !card_present) |=> !off_n);
endmodule

bind cardpwr_seq cardpwr_seq_chk u_chk (
   .clk(clk), .rst_n(rst_n), .start_n(start_n), .card_present(card_present),
   .supply_alarm(supply_alarm), .fault_ovc(fault_ovc), .fault_short(fault_short),
   .host_rst_ctl(host_rst_ctl), .boost_en(boost_en), .clamp_en(clamp_en),
   .vcc_en(vcc_en), .io_en(io_en), .card_clk_en(card_clk_en),
   .card_rst(card_rst), .off_n(off_n)
);

// File: tb/sim_cardpwr_seq.sv
`timescale 1ns/1ps
module sim_cardpwr_seq;
   localparam int TICK_DIV = 64;
   localparam int HALF     = TICK_DIV / 2;
   localparam int T2H = 3, T3H = 8, T5H = 14, STEPH = 2;
   localparam int DONEH = 4 * STEPH;
   localparam logic [6:0] IDLE_V = 7'b0100001;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_n = 1'b0, card_present = 1'b1, supply_alarm = 1'b0;
   logic fault_ovc = 1'b0, fault_short = 1'b0, host_rst_ctl = 1'b0;
   logic boost_en, clamp_en, vcc_en, io_en, card_clk_en, card_rst, off_n;
   int errors = 0;
   int checks = 0;

   always #10 clk = ~clk;

   cardpwr_seq #(.TICK_DIV(TICK_DIV), .T2_HALF(T2H), .T3_HALF(T3H),
                 .T5_HALF(T5H), .STEP_HALF(STEPH)) u0 (
      .clk(clk), .rst_n(rst_n), .start_n(start_n), .card_present(card_present),
      .supply_alarm(supply_alarm), .fault_ovc(fault_ovc), .fault_short(fault_short),
      .host_rst_ctl(host_rst_ctl), .boost_en(boost_en), .clamp_en(clamp_en),
      .vcc_en(vcc_en), .io_en(io_en), .card_clk_en(card_clk_en),
      .card_rst(card_rst), .off_n(off_n)
   );

   function automatic logic [6:0] outs();
      return {boost_en, clamp_en, vcc_en, io_en, card_clk_en, card_rst, off_n};
   endfunction

   function automatic logic hostpat(int m);
      return ((m / 7) % 2) == 1;
   endfunction

   function automatic logic [6:0] exp_ramp(int m, logic host);
      int h;
      h = m / HALF;
      if (h >= T5H) return {1'b1, 1'b0, 1'b1, 1'b1, 1'b1, ~host, 1'b1};
      return {1'b1, ~(h >= T2H), (h >= T2H), (h >= T3H), (h >= T3H) & host, 1'b0, 1'b1};
   endfunction

   function automatic logic [6:0] exp_down(int m, bit vw, bit iw, bit hold,
                                          bit off_low, bit off_after_low);
      int h;
      h = m / HALF;
      if (h >= DONEH) return {6'b010000, ~off_after_low};
      return {1'b1, ~vw, vw & (h < 3*STEPH), iw & (h < 2*STEPH),
              hold & (h < STEPH), 1'b0, ~off_low};
   endfunction

   function automatic string ramp_tag(int m);
      if (m < T2H*HALF) return "R3";
      if (m < T3H*HALF) return "R4";
      if (m < T5H*HALF) return "R5 R6";
      return "R7";
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [6:0] act, input logic [6:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s at %0t actual=%b expected=%b", tag, $time, act, exp);
      end
   endtask

   task automatic idle_for(input int n, input string tag);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         chk(outs() == IDLE_V, tag, outs(), IDLE_V);
      end
   endtask

   // Raise then drop the request, sweep the activation up to edge stop_m.
   task automatic activate_run(input int stop_m);
      @(negedge clk); start_n = 1'b1;
      @(negedge clk); start_n = 1'b0; host_rst_ctl = hostpat(0);
      for (int m = 0; m <= stop_m; m++) begin
         @(negedge clk);
         chk(outs() == exp_ramp(m, host_rst_ctl), ramp_tag(m), outs(), exp_ramp(m, host_rst_ctl));
         host_rst_ctl = hostpat(m + 1);
      end
   endtask

   task automatic down_run(input int n, input bit vw, input bit iw, input bit hold,
                           input bit off_low, input bit off_after_low,
                           input bit poke, input string tag);
      for (int m = 0; m < n; m++) begin
         @(negedge clk);
         chk(outs() == exp_down(m, vw, iw, hold, off_low, off_after_low), tag,
             outs(), exp_down(m, vw, iw, hold, off_low, off_after_low));
         if (m == 0) begin
            fault_ovc = 1'b0; fault_short = 1'b0; supply_alarm = 1'b0;
         end
         if (poke) begin
            if (m == 50) start_n = 1'b0;
            if (m == 60) start_n = 1'b1;
            if (m == 100) start_n = 1'b0;
         end
      end
   endtask

   function automatic bit hold_at(int m);
      int h;
      h = m / HALF;
      if (h >= T5H) return 1'b1;
      return (h >= T3H) && host_rst_ctl;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int sm;
      bit hd;
      // R1: reset values, request held low through reset
      repeat (3) @(negedge clk);
      chk(outs() == IDLE_V, "R1", outs(), IDLE_V);
      rst_n = 1'b1;
      idle_for(30, "R2 held request after reset");

      // R2: falling edge without card, then with alarm
      @(negedge clk); start_n = 1'b1; card_present = 1'b0;
      @(negedge clk); start_n = 1'b0;
      idle_for(40, "R2 no card");
      @(negedge clk); start_n = 1'b1; card_present = 1'b1; supply_alarm = 1'b1;
      @(negedge clk); start_n = 1'b0;
      idle_for(40, "R2 alarm");
      supply_alarm = 1'b0;

      // Full activation, normal release with request pokes during shutdown
      sm = T5H*HALF + 40;
      activate_run(sm);
      start_n = 1'b1;
      down_run(DONEH*HALF + 10, 1, 1, 1, 0, 0, 1, "R8 R9");
      idle_for(60, "R9");

      // Early release before the supply step
      activate_run(40);
      start_n = 1'b1;
      down_run(DONEH*HALF + 10, 0, 0, 0, 0, 0, 0, "R8 early");

      // Overcurrent inside the clock window
      sm = 300;
      activate_run(sm);
      hd = hold_at(sm);
      fault_ovc = 1'b1;
      down_run(DONEH*HALF + 10, 1, 1, hd, 1, 0, 0, "R10 R11 overcurrent");

      // Short while fully active
      sm = T5H*HALF + 20;
      activate_run(sm);
      fault_short = 1'b1;
      down_run(DONEH*HALF + 10, 1, 1, 1, 1, 0, 0, "R10 R11 short");

      // Supply drop inside the supply phase
      sm = 150;
      activate_run(sm);
      supply_alarm = 1'b1;
      down_run(DONEH*HALF + 10, 1, 0, 0, 1, 0, 0, "R10 R11 alarm");

      // Card removal while fully active
      sm = T5H*HALF + 30;
      activate_run(sm);
      card_present = 1'b0;
      down_run(DONEH*HALF + 10, 1, 1, 1, 1, 1, 0, "R10 R12 removal");
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         chk(off_n == 1'b0, "R12 latched", {6'b0, off_n}, 7'b0);
      end
      card_present = 1'b1;
      @(negedge clk);
      chk(outs() == IDLE_V, "R12 reinsert", outs(), IDLE_V);
      idle_for(20, "R2 no fresh edge");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule